// File: doc/BRIEF.md
# Threshold-Qualified Event Counter

This block is one performance-monitor counter. On every clock cycle it receives a multi-bit count of the events seen in that cycle. It decides whether that cycle qualifies by comparing the count against a programmed threshold. A qualifying cycle then adds either its full event count or a single unit to a wide accumulator.

Configuration is loaded through a one-cycle write strobe. Each write carries a threshold, a comparison code and a count-mode bit. A fixed capability output reports the largest threshold the block accepts. A write that asks for more than that is refused, and the refusal is recorded in a sticky error flag. The accumulator wraps on overflow and records the wrap in a sticky flag. Enable and clear inputs control the accumulator.

Top module: `thr_evcnt`

## Requirements
- R1: After reset the counter is 0, the overflow and error flags are 0, and the threshold, comparison code and count-mode bit are all 0.
- R2: While the stored threshold is 0, every enabled cycle adds the raw event count, and neither the comparison code nor the count-mode bit has any effect.
- R3: With a nonzero threshold, the comparison code selects the test of event count E against threshold T: 0 is E != T, 1 is E == T, 2 is E >= T, 3 is E < T. A cycle that passes adds E; a cycle that fails adds 0.
- R4: With a nonzero threshold and the count-mode bit set, each passing cycle adds exactly 1. A cycle with zero events can pass code 0 or code 3: it then adds 1 in count mode and 0 otherwise.
- R5: A configuration write takes effect for the events of the cycle after the write. The events presented in the write cycle itself use the previous configuration.
- R6: A write whose threshold exceeds the capability value is refused. The previous threshold, comparison code and count-mode bit are kept, and the error flag is set. The flag stays set until a cycle with err_clr high and no refused write in that same cycle.
- R7: thresh_cap always equals the TH_MAX parameter, and TH_MAX must fit in the 12-bit threshold field. A block built with TH_MAX = 0 refuses any nonzero threshold and still accepts 0.
- R8: While en is low and clr is low, the counter and the overflow flag hold their values.
- R9: clr forces the counter and the overflow flag to 0 on the next edge. clr takes priority over en and over any events.
- R10: The counter wraps modulo 2^CNT_W. A carry out of the top bit sets the overflow flag, which stays set until clr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_thresh | input | TH_W | Threshold to write |
| cfg_cmp | input | 2 | Comparison code to write |
| cfg_unit | input | 1 | Count-mode bit to write: 1 adds one per passing cycle |
| err_clr | input | 1 | Write-one-to-clear for the error flag |
| evt | input | EV_W | Number of events in this cycle |
| en | input | 1 | Accumulate enable |
| clr | input | 1 | Synchronous counter clear |
| count | output | CNT_W | Accumulated value |
| ovf | output | 1 | Sticky wrap flag |
| cfg_err | output | 1 | Sticky refused-write flag |
| thresh_cap | output | TH_W | Largest threshold accepted |

## Verification
The bench builds two copies of the block. The main copy uses a 16-bit accumulator, so that wraps and the overflow flag occur within a few hundred cycles of large event counts. Its TH_MAX of 255 lets thresholds on both sides of the 8-bit event range and of the limit itself be written. The second copy is built with TH_MAX = 0, which shows the case where thresholding is absent: every nonzero threshold is refused while raw counting continues. Random configuration writes, event counts and control pulses are mixed with directed cases for each comparison code, for zero-event cycles, for refused writes and for clear priority.

// File: rtl/thr_evcnt.sv
module thr_evcnt #(
  parameter int EV_W   = 8,
  parameter int CNT_W  = 64,
  parameter int TH_W   = 12,
  parameter int TH_MAX = 255
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [TH_W-1:0]  cfg_thresh,
  input  logic [1:0]       cfg_cmp,
  input  logic             cfg_unit,
  input  logic             err_clr,
  input  logic [EV_W-1:0]  evt,
  input  logic             en,
  input  logic             clr,
  output logic [CNT_W-1:0] count,
  output logic             ovf,
  output logic             cfg_err,
  output logic [TH_W-1:0]  thresh_cap
);
  localparam int CMP_W = (EV_W > TH_W) ? EV_W : TH_W;
  localparam logic [TH_W-1:0] CAP = TH_W'(TH_MAX);

  logic [TH_W-1:0]  th_q;
  logic [1:0]       cmp_q;
  logic             unit_q;
  logic             reject;
  logic             hit;
  logic [EV_W-1:0]  step;
  logic [CNT_W:0]   sum;
  logic [CMP_W-1:0] ev_x, th_x;

  assign thresh_cap = CAP;
  assign reject     = cfg_thresh > CAP;
  assign ev_x       = CMP_W'(evt);
  assign th_x       = CMP_W'(th_q);

  always_comb begin
    case (cmp_q)
      2'd0:    hit = ev_x != th_x;
      2'd1:    hit = ev_x == th_x;
      2'd2:    hit = ev_x >= th_x;
      default: hit = ev_x <  th_x;
    endcase
  end

  always_comb begin
    if (th_q == '0)  step = evt;
    else if (!hit)   step = '0;
    else if (unit_q) step = EV_W'(1);
    else             step = evt;
  end

  assign sum = {1'b0, count} + {{(CNT_W + 1 - EV_W){1'b0}}, step};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      th_q   <= '0;
      cmp_q  <= '0;
      unit_q <= 1'b0;
    end else if (cfg_we && !reject) begin
      th_q   <= cfg_thresh;
      cmp_q  <= cfg_cmp;
      unit_q <= cfg_unit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_err <= 1'b0;
    else        cfg_err <= (cfg_err & ~err_clr) | (cfg_we & reject);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      ovf   <= 1'b0;
    end else if (clr) begin
      count <= '0;
      ovf   <= 1'b0;
    end else if (en) begin
      count <= sum[CNT_W-1:0];
      if (sum[CNT_W]) ovf <= 1'b1;
    end
  end
endmodule

// File: rtl/thr_evcnt_chk.sv
module thr_evcnt_chk #(
  parameter int EV_W   = 8,
  parameter int CNT_W  = 64,
  parameter int TH_W   = 12,
  parameter int TH_MAX = 255
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_we,
  input logic [TH_W-1:0]  cfg_thresh,
  input logic [EV_W-1:0]  evt,
  input logic             en,
  input logic             clr,
  input logic [CNT_W-1:0] count,
  input logic             ovf,
  input logic             cfg_err,
  input logic [TH_W-1:0]  th_q,
  input logic             unit_q
);
  // R9
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count == '0) && !ovf);

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !clr) |=> $stable(count) && $stable(ovf));

  // R6
  reject_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_thresh > TH_W'(TH_MAX)) |=> cfg_err && $stable(th_q));

  // R2
  raw_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr && th_q == '0) |=> count == $past(count) + CNT_W'($past(evt)));

  // R4
  unit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr && th_q != '0 && unit_q) |=> (count - $past(count)) <= CNT_W'(1));

  // R10
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !clr) |=> ovf);
endmodule

bind thr_evcnt thr_evcnt_chk #(
  .EV_W(EV_W), .CNT_W(CNT_W), .TH_W(TH_W), .TH_MAX(TH_MAX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_thresh(cfg_thresh),
  .evt(evt), .en(en), .clr(clr), .count(count), .ovf(ovf),
  .cfg_err(cfg_err), .th_q(th_q), .unit_q(unit_q)
);

// File: tb/test_thr_evcnt.sv
module test_thr_evcnt;
  localparam int CW = 16;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, cfg_unit = 0, err_clr = 0, en = 0, clr = 0;
  logic [11:0] cfg_thresh = 0;
  logic [1:0]  cfg_cmp = 0;
  logic [7:0]  evt = 0;
  logic [CW-1:0] count, count2;
  logic ovf, ovf2, cfg_err, cfg_err2;
  logic [11:0] cap, cap2;

  always #2.5 clk = ~clk;

  thr_evcnt #(.EV_W(8), .CNT_W(CW), .TH_W(12), .TH_MAX(255)) i_thr_evcnt (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_thresh(cfg_thresh),
    .cfg_cmp(cfg_cmp), .cfg_unit(cfg_unit), .err_clr(err_clr), .evt(evt),
    .en(en), .clr(clr), .count(count), .ovf(ovf), .cfg_err(cfg_err),
    .thresh_cap(cap));

  thr_evcnt #(.EV_W(8), .CNT_W(CW), .TH_W(12), .TH_MAX(0)) i_thr_evcnt_nocap (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_thresh(cfg_thresh),
    .cfg_cmp(cfg_cmp), .cfg_unit(cfg_unit), .err_clr(err_clr), .evt(evt),
    .en(en), .clr(clr), .count(count2), .ovf(ovf2), .cfg_err(cfg_err2),
    .thresh_cap(cap2));

  int total = 0, bad = 0;
  logic [CW-1:0] m_cnt = 0, m_cnt2 = 0;
  logic m_ovf = 0, m_ovf2 = 0, m_err = 0, m_err2 = 0;
  logic [11:0] m_th = 0;
  logic [1:0]  m_cmp = 0;
  logic        m_unit = 0;

  function automatic logic [7:0] inc_of(logic [7:0] e, logic [11:0] t,
                                        logic [1:0] c, logic u);
    logic pass;
    if (t == 0) return e;
    case (c)
      2'd0: pass = {4'd0, e} != t;
      2'd1: pass = {4'd0, e} == t;
      2'd2: pass = {4'd0, e} >= t;
      default: pass = {4'd0, e} < t;
    endcase
    if (!pass) return 8'd0;
    return u ? 8'd1 : e;
  endfunction

  task automatic chk(input string tag, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic we, input logic [11:0] th, input logic [1:0] cm,
                     input logic un, input logic ec, input logic [7:0] ev,
                     input logic e, input logic c, input string tag);
    logic [CW:0] s;
    logic rej, rej2;
    cfg_we = we; cfg_thresh = th; cfg_cmp = cm; cfg_unit = un;
    err_clr = ec; evt = ev; en = e; clr = c;
    if (c) begin
      m_cnt = 0; m_ovf = 0; m_cnt2 = 0; m_ovf2 = 0;
    end else if (e) begin
      s = {1'b0, m_cnt} + (CW+1)'(inc_of(ev, m_th, m_cmp, m_unit));
      m_cnt = s[CW-1:0]; if (s[CW]) m_ovf = 1;
      s = {1'b0, m_cnt2} + (CW+1)'(ev);
      m_cnt2 = s[CW-1:0]; if (s[CW]) m_ovf2 = 1;
    end
    rej = we && th > 255;
    rej2 = we && th != 0;
    if (we && !rej) begin m_th = th; m_cmp = cm; m_unit = un; end
    m_err  = (m_err  & ~ec) | rej;
    m_err2 = (m_err2 & ~ec) | rej2;
    @(posedge clk);
    @(negedge clk);
    chk({tag, " count"}, count, m_cnt);
    chk({tag, " ovf"}, ovf, m_ovf);
    chk({tag, " err"}, cfg_err, m_err);
    chk({tag, " R7 nocap count"}, count2, m_cnt2);
    chk({tag, " R7 nocap err"}, cfg_err2, m_err2);
  endtask

  task automatic ev_only(input logic [7:0] ev, input string tag);
    cyc(0, 0, 0, 0, 0, ev, 1, 0, tag);
  endtask

  initial begin
    #2000000;
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234));
    repeat (3) @(negedge clk);
    chk("R1 count", count, 0);
    chk("R1 ovf", ovf, 0);
    chk("R1 err", cfg_err, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R7 cap", cap, 255);
    chk("R7 cap nocap", cap2, 0);

    // R2: threshold 0, cmp/unit ignored
    cyc(1, 0, 2'd3, 1, 0, 8'd9, 1, 0, "R2 write");
    ev_only(8'd7, "R2 raw");
    ev_only(8'd0, "R2 zero");
    // R3 / R5: write GE 2 with events 1 in same cycle (old config)
    cyc(1, 12'd2, 2'd2, 0, 0, 8'd1, 1, 0, "R5 old cfg");
    ev_only(8'd1, "R3 ge fail");
    ev_only(8'd5, "R3 ge pass");
    cyc(1, 12'd4, 2'd1, 0, 0, 8'd4, 1, 0, "R3 eq write");
    ev_only(8'd4, "R3 eq pass");
    ev_only(8'd3, "R3 eq fail");
    cyc(1, 12'd4, 2'd0, 0, 0, 8'd0, 1, 0, "R3 ne write");
    ev_only(8'd4, "R3 ne fail");
    ev_only(8'd0, "R4 ne zero raw");
    cyc(1, 12'd10, 2'd3, 1, 0, 8'd0, 1, 0, "R4 lt unit write");
    ev_only(8'd0, "R4 lt zero unit");
    ev_only(8'd9, "R4 lt unit");
    ev_only(8'd10, "R4 lt fail");
    cyc(1, 12'd200, 2'd2, 0, 0, 8'd0, 1, 0, "R3 ge 200");
    ev_only(8'd255, "R3 ge 255");
    // R6: refused write, keep config, sticky flag
    cyc(1, 12'd256, 2'd3, 1, 0, 8'd0, 1, 0, "R6 reject");
    ev_only(8'd201, "R6 config kept");
    cyc(0, 0, 0, 0, 0, 8'd0, 1, 0, "R6 sticky");
    cyc(1, 12'd4095, 0, 0, 1, 8'd0, 1, 0, "R6 set beats clear");
    cyc(0, 0, 0, 0, 1, 8'd0, 1, 0, "R6 clear");
    cyc(1, 12'd255, 2'd2, 0, 0, 8'd0, 1, 0, "R6 max accepted");
    ev_only(8'd255, "R6 max pass");
    // R8: enable low
    cyc(0, 0, 0, 0, 0, 8'd255, 0, 0, "R8 hold");
    // R9: clr priority
    cyc(0, 0, 0, 0, 0, 8'd255, 1, 1, "R9 clr");
    // R10: wrap with raw counting
    cyc(1, 0, 0, 0, 0, 8'd0, 1, 0, "R10 raw cfg");
    for (int i = 0; i < 300; i++) ev_only(8'd255, "R10 wrap");
    chk("R10 ovf seen", ovf, 1);
    cyc(0, 0, 0, 0, 0, 8'd0, 1, 1, "R9 clr ovf");

    for (int i = 0; i < 3000; i++) begin
      logic we, c, e, ec;
      logic [11:0] th;
      we = ($urandom % 8) == 0;
      th = ($urandom % 4 == 0) ? 12'($urandom % 4096) : 12'($urandom % 12);
      c  = ($urandom % 64) == 0;
      e  = ($urandom % 8) != 0;
      ec = ($urandom % 16) == 0;
      cyc(we, th, 2'($urandom), 1'($urandom), ec, 8'($urandom), e, c, "R3 random");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule